// File: doc/BRIEF.md
# PWM Timer Tick Generator

This block turns one base clock into a set of per-channel tick enables for a multi-channel PWM timer. It has two 8-bit prescalers. The channels of the low group (channels 0 and 1 by default) share one prescaler, and the remaining channels share the other. Each channel has its own 4-bit selector code. The code either divides its group's prescaled tick by a power of two, or passes through the external timer strobe of that group. The strobes are single-cycle pulses that are already synchronised to the base clock. Downstream counters advance only in cycles where their tick is high.

Two configuration registers are written and read through a plain word port. The prescaler register holds both prescale values. The selector register holds the per-channel codes. A written value is staged, and the running logic of a group only picks it up when that group's prescaler wraps. This way a tick interval already in progress finishes at its old length.

Top module: `pwm_tick_gen`

## Requirements
- R1: While rst_ni is low, both registers read as zero and every tick_o bit is low. After release, every channel runs with prescale 0 and selector code 0.
- R2: Register map:
  - At address 0x0, bits [7:0] hold prescaler A and bits [15:8] hold prescaler B. The higher bits read 0.
  - At address 0x4, channel c owns bits [4c+3:4c]. Bits above the last channel read 0.
  - rdata_o shows the stored value of the addressed register in the same cycle. Any other address reads 0.
  - A write to any other address changes neither register.
- R3: A prescale value P yields one prescaled tick every P+1 base cycles. tick_o is registered, one cycle behind the internal tick.
- R4: Channels below GRP0_CH (default 2) use prescaler A and ext_tick_i[0]. All higher channels use prescaler B and ext_tick_i[1].
- R5: A selector code m whose bit in EXT_MASK is clear gives one tick every (P+1)·2^(m+DIV_BASE) base cycles. Codes above 3 act as code 3. By default DIV_BASE is 0, so the ratios are 1, 2, 4 and 8.
- R6: A selector code m whose bit in EXT_MASK is set makes tick_o of that channel equal its group's ext_tick_i one cycle later. The default mask selects code 4.
- R7: New prescale and selector values of a group take effect in the cycle after that group's next prescaler wrap. The interval in progress is never shortened.
- R8: Divided channels of one group share one divider phase, so every tick of a slower channel coincides with a tick of a faster channel in the same group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| ext_tick_i | input | 2 | Synchronised external strobes, one per group |
| tick_o | output | NUM_CH | Tick enable per channel |

## Verification
The assertions assume that ext_tick_i is a clean signal in the base clock domain and that writes are sampled on the rising edge only. The bench therefore drives every input on the falling edge and holds it for whole cycles. External strobes are given only while a channel has settled onto its external code, and each strobe lasts a single cycle. Tick intervals are measured only after a settle time longer than one full old interval, so that the deferred update has certainly landed.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int unsigned NUM_GRP   = 2;
  localparam int unsigned MAX_CODE  = 3;
  localparam logic [2:0]  ADDR_PRE  = 3'h0;
  localparam logic [2:0]  ADDR_SEL  = 3'h4;

  function automatic int unsigned grp_of(input int unsigned ch, input int unsigned grp0_ch);
    return (ch < grp0_ch) ? 0 : 1;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PRE_W = 8,
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRE_W-1:0] stage_i,
  output logic             wrap_o,
  output logic [PRE_W-1:0] act_o,
  output logic [PRE_W-1:0] cnt_o,
  output logic [DIV_W-1:0] div_cnt_o
);
  logic [PRE_W-1:0] cnt_q, act_q;
  logic [DIV_W-1:0] div_q;

  assign wrap_o    = (cnt_q == act_q);
  assign act_o     = act_q;
  assign cnt_o     = cnt_q;
  assign div_cnt_o = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
      div_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      act_q <= stage_i;      // new value only at the interval boundary
      div_q <= div_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_chan_sel.sv
module pwm_chan_sel #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DIV_W    = 3,
  parameter int unsigned DIV_BASE = 0,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0010
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wrap_i,
  input  logic [SEL_W-1:0] stage_code_i,
  input  logic [DIV_W-1:0] div_cnt_i,
  input  logic             ext_i,
  output logic             ext_sel_o,
  output logic             tick_o
);
  import pwm_tick_pkg::*;

  logic [SEL_W-1:0] code_q;
  logic [DIV_W-1:0] mask;
  logic             hit;
  int unsigned      exp_w;

  assign ext_sel_o = EXT_MASK[code_q];

  always_comb begin
    exp_w = ((int'(code_q) > int'(MAX_CODE)) ? MAX_CODE : int'(code_q)) + DIV_BASE;
    for (int i = 0; i < int'(DIV_W); i++) mask[i] = (i < int'(exp_w));
    hit = wrap_i && ((div_cnt_i & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= ext_sel_o ? ext_i : hit;
      if (wrap_i) code_q <= stage_code_i;
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned GRP0_CH  = 2,
  parameter int unsigned PRE_W    = 8,
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DIV_BASE = 0,
  parameter logic [(1<<SEL_W)-1:0] EXT_MASK = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [1:0]        ext_tick_i,
  output logic [NUM_CH-1:0] tick_o
);
  import pwm_tick_pkg::*;

  localparam int unsigned PRE_TOT = NUM_GRP * PRE_W;
  localparam int unsigned SEL_TOT = NUM_CH * SEL_W;
  localparam int unsigned DIV_W   = MAX_CODE + DIV_BASE;

  logic [PRE_TOT-1:0]                 cfg0_q;
  logic [SEL_TOT-1:0]                 cfg1_q;
  logic [NUM_GRP-1:0]                 wrap;
  logic [NUM_GRP-1:0][PRE_W-1:0]      act_pre, pre_cnt;
  logic [NUM_GRP-1:0][DIV_W-1:0]      div_cnt;
  logic [NUM_CH-1:0]                  ext_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg0_q <= '0;
      cfg1_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == ADDR_PRE) cfg0_q <= wdata_i[PRE_TOT-1:0];
      if (addr_i == ADDR_SEL) cfg1_q <= wdata_i[SEL_TOT-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_PRE) rdata_o[PRE_TOT-1:0] = cfg0_q;
    if (addr_i == ADDR_SEL) rdata_o[SEL_TOT-1:0] = cfg1_q;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
    pwm_prescaler #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_pre (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stage_i   (cfg0_q[g*PRE_W +: PRE_W]),
      .wrap_o    (wrap[g]),
      .act_o     (act_pre[g]),
      .cnt_o     (pre_cnt[g]),
      .div_cnt_o (div_cnt[g])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned G = grp_of(c, GRP0_CH);
    pwm_chan_sel #(
      .SEL_W(SEL_W), .DIV_W(DIV_W), .DIV_BASE(DIV_BASE), .EXT_MASK(EXT_MASK)
    ) u_sel (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wrap_i       (wrap[G]),
      .stage_code_i (cfg1_q[c*SEL_W +: SEL_W]),
      .div_cnt_i    (div_cnt[G]),
      .ext_i        (ext_tick_i[G]),
      .ext_sel_o    (ext_sel[c]),
      .tick_o       (tick_o[c])
    );
  end
endmodule

// File: rtl/pwm_tick_chk.sv
module pwm_tick_chk #(
  parameter int unsigned NUM_CH  = 5,
  parameter int unsigned GRP0_CH = 2,
  parameter int unsigned PRE_W   = 8,
  parameter int unsigned PRE_TOT = 16,
  parameter int unsigned SEL_TOT = 20
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [1:0]                ext_tick_i,
  input logic [NUM_CH-1:0]         tick_o,
  input logic [1:0]                wrap,
  input logic [1:0][PRE_W-1:0]     act_pre,
  input logic [1:0][PRE_W-1:0]     pre_cnt,
  input logic [NUM_CH-1:0]         ext_sel,
  input logic [PRE_TOT-1:0]        cfg0_q,
  input logic [SEL_TOT-1:0]        cfg1_q
);
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(cfg0_q) && $stable(cfg1_q))); // R2

  for (genvar g = 0; g < 2; g++) begin : g_grp
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pre_cnt[g] <= act_pre[g]); // R3
    AST_WRAP_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap[g] |=> (pre_cnt[g] == '0)); // R3
    AST_HOLD_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wrap[g] |=> $stable(act_pre[g])); // R7
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned G = (c < GRP0_CH) ? 0 : 1;
    AST_EXT_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ext_sel[c] |=> (tick_o[c] == $past(ext_tick_i[G]))); // R6
    AST_DIV_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ext_sel[c] && !wrap[G]) |=> !tick_o[c]); // R5
  end
endmodule

bind pwm_tick_gen pwm_tick_chk #(
  .NUM_CH(NUM_CH), .GRP0_CH(GRP0_CH), .PRE_W(PRE_W), .PRE_TOT(PRE_TOT), .SEL_TOT(SEL_TOT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .ext_tick_i(ext_tick_i),
  .tick_o(tick_o), .wrap(wrap), .act_pre(act_pre), .pre_cnt(pre_cnt),
  .ext_sel(ext_sel), .cfg0_q(cfg0_q), .cfg1_q(cfg1_q)
);

// File: tb/sim_pwm_tick_gen.sv
module sim_pwm_tick_gen;
  localparam int NCH = 5;
  localparam int NV  = 5;
  // {prescale reg, selector reg, expected interval ch0..ch4}
  localparam logic [75:0] VEC [NV] = '{
    {16'h0000, 20'h00000, 8'd1,  8'd1,  8'd1,  8'd1,  8'd1 },
    {16'h0402, 20'h32031, 8'd6,  8'd24, 8'd5,  8'd20, 8'd40},
    {16'h0107, 20'h01320, 8'd8,  8'd32, 8'd16, 8'd4,  8'd2 },
    {16'h0001, 20'h206F5, 8'd16, 8'd16, 8'd8,  8'd1,  8'd4 },
    {16'h0900, 20'h11111, 8'd2,  8'd2,  8'd20, 8'd20, 8'd20}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] ext = '0;
  logic [NCH-1:0] tick;
  int n_chk = 0, n_err = 0, cyc = 0;
  int last_t [NCH];
  int ival [NCH];
  bit done = 0;

  always #2 clk = ~clk;

  pwm_tick_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ext_tick_i(ext), .tick_o(tick)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int c = 0; c < NCH; c++)
      if (tick[c]) begin
        ival[c]   <= cyc - last_t[c];
        last_t[c] <= cyc;
      end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'h0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k, viol, n3;
    for (int c = 0; c < NCH; c++) begin last_t[c] = 0; ival[c] = 0; end

    // R1 reset state
    wait_cyc(3);
    addr = 3'h0; #1 chk("R1 prescale reg in reset", rdata, 32'h0);
    addr = 3'h4; #1 chk("R1 selector reg in reset", rdata, 32'h0);
    chk("R1 ticks low in reset", 32'(tick), 32'h0);
    @(negedge clk); rst_n = 1'b1; addr = 3'h0;

    // R3 R4 R5 table walk
    for (int v = 0; v < NV; v++) begin
      wr(3'h0, 32'(VEC[v][75:60]));
      wr(3'h4, 32'(VEC[v][59:40]));
      wait_cyc(200);
      rd(3'h0, d); chk("R2 prescale readback", d, 32'(VEC[v][75:60]));
      rd(3'h4, d); chk("R2 selector readback", d, 32'(VEC[v][59:40]));
      for (int c = 0; c < NCH; c++)
        chk($sformatf("R3 R4 R5 vec%0d ch%0d interval", v, c), 32'(ival[c]),
            32'(VEC[v][39-8*c -: 8]));
    end

    // R8 shared phase: group B, ch3 interval 4, ch4 interval 2
    wr(3'h0, 32'h0107); wr(3'h4, 32'h01320);
    wait_cyc(100);
    viol = 0; n3 = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tick[3]) n3++;
      if (tick[3] && !tick[4]) viol++;
    end
    chk("R8 slower tick without faster tick", 32'(viol), 32'h0);
    chk("R8 slower channel ticked", 32'(n3 > 0), 32'h1);

    // R2 field widths and ignored addresses
    wr(3'h0, 32'h0000_0000); wr(3'h4, 32'h0);
    wait_cyc(300);
    wr(3'h2, 32'hFFFF_FFFF);
    wr(3'h6, 32'hFFFF_FFFF);
    rd(3'h0, d); chk("R2 prescale unchanged by other address", d, 32'h0);
    rd(3'h4, d); chk("R2 selector unchanged by other address", d, 32'h0);
    rd(3'h2, d); chk("R2 unmapped address reads zero", d, 32'h0);
    chk("R2 ticks unchanged after ignored writes", 32'(tick), 32'h1F);
    wr(3'h4, 32'hFFFF_FFFF);
    rd(3'h4, d); chk("R2 selector upper bits read zero", d, 32'h000F_FFFF);
    wr(3'h4, 32'h0);
    wr(3'h0, 32'hFFFF_FFFF);
    rd(3'h0, d); chk("R2 prescale upper bits read zero", d, 32'h0000_FFFF);
    wr(3'h0, 32'h0);
    wait_cyc(600);

    // R6 external strobes: code 4 on ch0 and ch3
    wr(3'h4, 32'h04004);
    wait_cyc(20);
    @(negedge clk); ext = 2'b01;
    @(negedge clk); ext = 2'b00;
    chk("R6 ch0 follows ext0", 32'(tick[0]), 32'h1);
    chk("R6 ch3 ignores ext0", 32'(tick[3]), 32'h0);
    chk("R4 divided ch1 keeps ticking", 32'(tick[1]), 32'h1);
    ext = 2'b10;
    @(negedge clk); ext = 2'b00;
    chk("R6 ch3 follows ext1", 32'(tick[3]), 32'h1);
    chk("R6 ch0 ignores ext1", 32'(tick[0]), 32'h0);
    @(negedge clk);
    chk("R6 no strobe no tick", 32'({tick[3], tick[0]}), 32'h0);

    // R7 deferred prescale change
    wr(3'h4, 32'h0); wr(3'h0, 32'h0009);
    wait_cyc(40);
    do @(negedge clk); while (!tick[0]);
    k = 0;
    wait_cyc(3); k += 3;
    wr(3'h0, 32'h0000); k += 2;
    do begin @(negedge clk); k++; end while (!tick[0] && k < 50);
    chk("R7 interval in progress kept", 32'(k), 32'd10);
    @(negedge clk);
    chk("R7 new prescale after wrap", 32'(tick[0]), 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule